// File: doc/BRIEF.md
# Frequency Lock Detector with Hysteresis

This block decides whether a recovered clock, after division down to the rate of a local reference, runs at the same frequency as that reference. It counts recovered-clock cycles over a fixed window of reference cycles and takes the magnitude of the difference from the window length. It then keeps a lock flag with two tolerances. A locked loop stays locked until the error grows past a wide limit. An unlocked loop returns to lock only once the error falls under a narrow limit, and that narrow limit is chosen by a pin.

The lock flag also drives a steering output for the loop. While lock is missing, or while an active-low force input is held low, the loop is told to track the reference clock. Otherwise it is told to track the data stream. The recovered count is taken in the recovered-clock domain. It crosses into the reference domain through a toggle request and acknowledge handshake, and the decision is made in the reference domain.

With the default window of 32768 reference cycles, one count of error is about 30 ppm. The wide limit of 16 counts is about 488 ppm, and the two relock limits of 1 and 4 counts are about 30 and 122 ppm.

Top module: `freq_lock_det`

## Requirements
- R1: While reset is low, and in the first cycle after it falls, `lockFlag` is 0 and `refSel` is 1.
- R2: After reset, the measurement that ends the first window is discarded, so `lockFlag` stays 0 for at least two full windows (2 × 2^WIN_LOG2 reference cycles).
- R3: While locked, a window whose count differs from 2^WIN_LOG2 by more than LOSE_CNT (16) clears `lockFlag`. This holds for a recovered clock that is too fast and for one that is too slow.
- R4: While locked, a window error of LOSE_CNT or less leaves `lockFlag` at 1. `lockFlag` changes only when a new measurement arrives.
- R5: With `relockWide` = 0, an unlocked detector sets `lockFlag` only after a window whose error is below RELOCK_NARROW (1), which means an exact count.
- R6: With `relockWide` = 1, an unlocked detector sets `lockFlag` after a window whose error is below RELOCK_WIDE (4).
- R7: While unlocked, a window error at or above the selected relock limit keeps `lockFlag` at 0, even when that error is within LOSE_CNT.
- R8: `refSel` is 1 whenever `lockFlag` is 0 or `forceRefN` is 0, and it is 0 otherwise.
- R9: Holding `forceRefN` low does not disturb the lock decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Reference clock; it sets the measurement window and the decision domain |
| rcvClk | input | 1 | Divided recovered clock whose cycles are counted |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| relockWide | input | 1 | Relock limit select: 0 picks the narrow limit, 1 picks the wide limit |
| forceRefN | input | 1 | Active low; steers the loop to the reference clock |
| lockFlag | output | 1 | 1 while the two frequencies are judged to agree |
| refSel | output | 1 | 1 steers the loop to the reference clock, 0 steers it to the data stream |

## Verification
The hardest condition to reach from the ports is an exact-count window. The narrow relock needs zero error, but a clock-domain handshake normally moves the capture point by one recovered cycle from one window to the next. The bench reaches it by giving the recovered clock exactly the reference period at a fixed phase offset, which keeps the handshake latency constant. Every other case uses recovered periods chosen so that the intended error, plus or minus one count, stays clear of each limit. The bench then waits three windows so that the decision rests on clean windows and not on the window in which the period changed.

// File: rtl/fld_pkg.sv
`timescale 1ns/1ps
package fld_pkg;
  // strobes from the reference-domain control to the datapath
  typedef struct packed {
    logic reqTgl;      // toggles once per completed window
  } ctlCmd_t;

  // results from the datapath back to the control
  typedef struct packed {
    logic ackLvl;      // synchronized acknowledge toggle
    logic tooFar;      // error above the loss limit
    logic closeEnough; // error below the selected relock limit
  } measStat_t;
endpackage

// File: rtl/fld_sync.sv
`timescale 1ns/1ps
module fld_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fld_datapath.sv
`timescale 1ns/1ps
module fld_datapath
  import fld_pkg::*;
#(
  parameter int WIN_LOG2      = 15,
  parameter int LOSE_CNT      = 16,
  parameter int RELOCK_WIDE   = 4,
  parameter int RELOCK_NARROW = 1,
  parameter int SYNC_STAGES   = 2
) (
  input  logic      refClk,
  input  logic      rcvClk,
  input  logic      rstN,
  input  logic      relockWide,
  input  ctlCmd_t   cmd,
  output measStat_t stat
);
  localparam int CW = WIN_LOG2 + 2;
  localparam logic [CW-1:0] WINDOW  = CW'(1) << WIN_LOG2;
  localparam logic [CW-1:0] CNT_MAX = '1;

  // recovered-clock domain
  logic          reqInRcv;
  logic          reqSeen;
  logic          ackTgl;
  logic [CW-1:0] rcvCnt;
  logic [CW-1:0] heldCnt;
  logic          capture;

  fld_sync #(.STAGES(SYNC_STAGES)) u_reqSync (
    .clk(rcvClk), .rstN(rstN), .d(cmd.reqTgl), .q(reqInRcv)
  );

  assign capture = reqInRcv ^ reqSeen;

  always_ff @(posedge rcvClk or negedge rstN) begin
    if (!rstN) begin
      reqSeen <= 1'b0;
      ackTgl  <= 1'b0;
      rcvCnt  <= '0;
      heldCnt <= '0;
    end else begin
      reqSeen <= reqInRcv;
      if (capture) begin
        heldCnt <= rcvCnt;
        rcvCnt  <= CW'(1);
        ackTgl  <= reqInRcv;
      end else if (rcvCnt != CNT_MAX) begin
        rcvCnt <= rcvCnt + CW'(1);
      end
    end
  end

  // back into the reference domain
  fld_sync #(.STAGES(SYNC_STAGES)) u_ackSync (
    .clk(refClk), .rstN(rstN), .d(ackTgl), .q(stat.ackLvl)
  );

  // heldCnt is stable whenever the control looks at the results
  logic [CW-1:0] diffMag;
  logic [CW-1:0] relockLim;

  always_comb begin
    if (heldCnt >= WINDOW) diffMag = heldCnt - WINDOW;
    else                   diffMag = WINDOW - heldCnt;
    relockLim        = relockWide ? CW'(RELOCK_WIDE) : CW'(RELOCK_NARROW);
    stat.tooFar      = diffMag > CW'(LOSE_CNT);
    stat.closeEnough = diffMag < relockLim;
  end
endmodule

// File: rtl/fld_ctrl.sv
`timescale 1ns/1ps
module fld_ctrl
  import fld_pkg::*;
#(
  parameter int WIN_LOG2 = 15
) (
  input  logic      refClk,
  input  logic      rstN,
  input  measStat_t stat,
  output ctlCmd_t   cmd,
  output logic      lockFlag
);
  logic [WIN_LOG2-1:0] winCnt;
  logic                reqTgl;
  logic                ackPrev;
  logic                primed;
  logic                lockR;
  logic                ackEdge;

  assign ackEdge = stat.ackLvl ^ ackPrev;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      winCnt  <= '0;
      reqTgl  <= 1'b0;
      ackPrev <= 1'b0;
      primed  <= 1'b0;
      lockR   <= 1'b0;
    end else begin
      winCnt  <= winCnt + WIN_LOG2'(1);
      if (&winCnt) reqTgl <= ~reqTgl;
      ackPrev <= stat.ackLvl;
      if (ackEdge) begin
        if (!primed)                        primed <= 1'b1; // first window is partial
        else if (lockR && stat.tooFar)      lockR  <= 1'b0;
        else if (!lockR && stat.closeEnough) lockR <= 1'b1;
      end
    end
  end

  assign cmd.reqTgl = reqTgl;
  assign lockFlag   = lockR;
endmodule

// File: rtl/freq_lock_det.sv
`timescale 1ns/1ps
module freq_lock_det
  import fld_pkg::*;
#(
  parameter int WIN_LOG2      = 15,
  parameter int LOSE_CNT      = 16,
  parameter int RELOCK_WIDE   = 4,
  parameter int RELOCK_NARROW = 1,
  parameter int SYNC_STAGES   = 2
) (
  input  logic refClk,
  input  logic rcvClk,
  input  logic rstN,
  input  logic relockWide,
  input  logic forceRefN,
  output logic lockFlag,
  output logic refSel
);
  ctlCmd_t   cmd;
  measStat_t stat;

  fld_ctrl #(.WIN_LOG2(WIN_LOG2)) u_ctrl (
    .refClk(refClk), .rstN(rstN), .stat(stat), .cmd(cmd), .lockFlag(lockFlag)
  );

  fld_datapath #(
    .WIN_LOG2(WIN_LOG2), .LOSE_CNT(LOSE_CNT), .RELOCK_WIDE(RELOCK_WIDE),
    .RELOCK_NARROW(RELOCK_NARROW), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .refClk(refClk), .rcvClk(rcvClk), .rstN(rstN), .relockWide(relockWide),
    .cmd(cmd), .stat(stat)
  );

  assign refSel = ~lockFlag | ~forceRefN;
endmodule

// File: rtl/fld_checker.sv
`timescale 1ns/1ps
module fld_checker #(
  parameter int WIN_LOG2 = 15
) (
  input logic refClk,
  input logic rstN,
  input logic lockFlag,
  input logic refSel,
  input logic forceRefN,
  input logic ackLvl,
  input logic tooFar,
  input logic closeEnough
);
  localparam int SW = WIN_LOG2 + 2;
  localparam logic [SW-1:0] TWO_WIN = SW'(2) << WIN_LOG2;

  logic [SW-1:0] sinceRst;
  logic          ackPrev;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      sinceRst <= '0;
      ackPrev  <= 1'b0;
    end else begin
      if (sinceRst != '1) sinceRst <= sinceRst + SW'(1);
      ackPrev <= ackLvl;
    end
  end

  a_r2_no_early_lock: assert property (@(posedge refClk) disable iff (!rstN)
    (sinceRst < TWO_WIN) |-> !lockFlag);

  a_r3_drop_needs_far: assert property (@(posedge refClk) disable iff (!rstN)
    $fell(lockFlag) |-> $past(tooFar));

  a_r6_rise_needs_close: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(lockFlag) |-> $past(closeEnough));

  a_r4_moves_on_ack: assert property (@(posedge refClk) disable iff (!rstN)
    !$stable(lockFlag) |-> $past(ackLvl != ackPrev));

  a_r8_force_steers: assert property (@(posedge refClk) disable iff (!rstN)
    !forceRefN |-> refSel);

  a_r8_unlocked_ref: assert property (@(posedge refClk) disable iff (!rstN)
    !lockFlag |-> refSel);

  a_r8_locked_data: assert property (@(posedge refClk) disable iff (!rstN)
    (lockFlag && forceRefN) |-> !refSel);
endmodule

bind freq_lock_det fld_checker #(.WIN_LOG2(WIN_LOG2)) u_chk (
  .refClk(refClk), .rstN(rstN), .lockFlag(lockFlag), .refSel(refSel),
  .forceRefN(forceRefN), .ackLvl(stat.ackLvl), .tooFar(stat.tooFar),
  .closeEnough(stat.closeEnough)
);

// File: tb/sim_freq_lock_det.sv
`timescale 1ns/1ps
module sim_freq_lock_det;
  localparam int TB_WIN_LOG2 = 10;
  localparam int WIN = 1 << TB_WIN_LOG2;
  localparam int SETTLE = 3 * WIN + 40;

  typedef struct packed {
    int unsigned perPs;
    bit          wide;
    bit          frcN;
    bit          expLock;
    bit          expSel;
    int unsigned req;
  } vec_t;

  localparam int NV = 11;
  // reference period 4000 ps, window 1024; error in counts is noted per row
  localparam vec_t VEC [NV] = '{
    '{4000, 1'b1, 1'b1, 1'b1, 1'b0, 6},  // R6: error 0, wide relock
    '{3961, 1'b1, 1'b1, 1'b1, 1'b0, 4},  // R4: +10 held while locked
    '{3923, 1'b1, 1'b1, 1'b0, 1'b1, 3},  // R3: +20 fast, lock lost
    '{3961, 1'b1, 1'b1, 1'b0, 1'b1, 7},  // R7: +10 not enough to relock
    '{3992, 1'b0, 1'b1, 1'b0, 1'b1, 5},  // R5: +2 narrow limit refuses
    '{3992, 1'b1, 1'b1, 1'b1, 1'b0, 6},  // R6: +2 wide limit accepts
    '{4080, 1'b1, 1'b1, 1'b0, 1'b1, 3},  // R3: -20 slow, lock lost
    '{4008, 1'b0, 1'b1, 1'b0, 1'b1, 5},  // R5: -2 narrow limit refuses
    '{4000, 1'b0, 1'b1, 1'b1, 1'b0, 5},  // R5: exact count relocks
    '{4000, 1'b0, 1'b0, 1'b1, 1'b1, 9},  // R9: forced, lock kept
    '{4039, 1'b1, 1'b1, 1'b1, 1'b0, 4}   // R4: -10 held while locked
  };

  logic refClk = 1'b0;
  logic rcvClk = 1'b0;
  logic rstN = 1'b0;
  logic relockWide = 1'b1;
  logic forceRefN = 1'b1;
  logic lockFlag;
  logic refSel;

  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;
  realtime hiNs = 2.0;
  realtime loNs = 2.0;

  freq_lock_det #(.WIN_LOG2(TB_WIN_LOG2)) u0 (
    .refClk(refClk), .rcvClk(rcvClk), .rstN(rstN), .relockWide(relockWide),
    .forceRefN(forceRefN), .lockFlag(lockFlag), .refSel(refSel)
  );

  always #2 refClk = ~refClk;

  initial begin
    #1.3;
    forever begin
      #(hiNs) rcvClk = 1'b1;
      #(loNs) rcvClk = 1'b0;
    end
  end

  task automatic setRcv(int unsigned ps);
    hiNs = (ps / 2) / 1000.0;
    loNs = (ps - ps / 2) / 1000.0;
  endtask

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic finish();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    setRcv(4000);
    repeat (5) @(negedge refClk);
    check("R1 lock in reset", lockFlag, 1'b0);
    check("R1 sel in reset", refSel, 1'b1);
    rstN = 1'b1;
    @(negedge refClk);
    check("R1 lock after reset", lockFlag, 1'b0);
    check("R8 sel while unlocked", refSel, 1'b1);
    // matching clocks with the wide limit; first window must still be ignored
    repeat (WIN + WIN / 2) @(negedge refClk);
    check("R2 lock after one window", lockFlag, 1'b0);
    repeat (WIN / 2 - 20) @(negedge refClk);
    check("R2 lock before second decision", lockFlag, 1'b0);

    for (int i = 0; i < NV; i++) begin
      setRcv(VEC[i].perPs);
      relockWide = VEC[i].wide;
      forceRefN  = VEC[i].frcN;
      repeat (SETTLE) @(negedge refClk);
      check($sformatf("R%0d lock vec %0d", VEC[i].req, i), lockFlag, VEC[i].expLock);
      check($sformatf("R8 sel vec %0d", i), refSel, VEC[i].expSel);
    end

    // R8: releasing the force hands the loop back to the data stream
    forceRefN = 1'b1;
    @(negedge refClk);
    check("R8 sel force released", refSel, 1'b0);

    // R1: reset taken while locked
    rstN = 1'b0;
    @(negedge refClk);
    check("R1 lock on mid-run reset", lockFlag, 1'b0);
    check("R1 sel on mid-run reset", refSel, 1'b1);

    done = 1'b1;
    finish();
  end

  initial begin
    repeat (150000) @(posedge refClk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish();
    end
  end
endmodule